// File: doc/BRIEF.md
# Timeout Table Tick Scanner

On each timer tick, software hands this block a pointer to the first entry of a table of 16-bit timeout counters and the number of entries to scan. Entries sit a fixed stride of 15 words apart. The block walks the table through a single-port synchronous memory port. It adds one to each counter that is running and writes the new value back. A counter holding zero is idle: it is read but never rewritten.

The walk ends in one of two ways. It stops at the first counter that rolls over to zero, with the pointer left on that entry and the count not decremented; the result code is 0. Otherwise it runs until the count is used up, and the result code is 1. The final pointer, the final count and the result code stay on the outputs after the one-cycle done pulse, so the caller can service the expired entry or resume the walk from there.

Top module: `tmo_sweep`

## Requirements
- R1: When `start` is high while the block is idle, `startPtr` and `startCnt` are loaded. `busy` is high from the next cycle up to and including the cycle in which `done` is high.
- R2: Each entry visit issues one read (`memEn`=1, `memWe`=0) at the current pointer. The data returns on `memRdata` one cycle later, and the block adds one to it modulo 2^16.
- R3: A stored word of zero is an idle counter. Its visit makes no write, so the memory word stays zero.
- R4: Any other value is written back incremented (`memEn`=1, `memWe`=1) to the address it was read from.
- R5: When the written value is zero, the walk ends with `resultSkip`=0. `ptrOut` then holds the address of that entry and `cntOut` holds the count it had when the entry was visited.
- R6: After an entry that did not expire, the pointer advances by 15 modulo 2^16 (wrapping from the top of the address space to the bottom) and the count drops by one.
- R7: The walk continues while the decremented count is nonzero. When it reaches zero, the walk ends with `resultSkip`=1 and `cntOut`=0.
- R8: A start with a count of zero visits the first entry before the count is tested. The count then wraps to 0xFFFF and the walk goes on.
- R9: `start` while `busy` is high is ignored. The walk in progress, its results and its single `done` pulse are unchanged.
- R10: `done` is high for exactly one cycle per walk. `ptrOut`, `cntOut` and `resultSkip` hold their final values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| startPtr | input | 16 | Address of the first table entry |
| startCnt | input | 16 | Number of entries to scan |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| resultSkip | output | 1 | 0 = a counter expired, 1 = table finished |
| ptrOut | output | 16 | Final pointer |
| cntOut | output | 16 | Final count |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, one cycle after the read |

## Verification
An all-idle table, with no writes and a full pointer advance, separates the idle rule from the write-back rule. A table of running counters that never roll over shows the increment and the stride. Tables that expire at the first, a middle, and the second entry separate an early stop from a full walk and show that the count is not decremented on expiry. Starts with counts of zero and one, a table that wraps past the top of the address space, and a second start pulsed in mid-walk check the do-while order, the modular pointer and the rule that a start while busy is ignored. After every walk, the whole memory image and the write count are compared with an independent model.

// File: rtl/tmo_sweep_pkg.sv
package tmo_sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_ADVANCE,
    ST_DONE
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rdReq;
    logic capture;
    logic wrReq;
    logic advance;
    logic endExpired;
    logic endFinished;
  } scanCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic rdZero;
    logic incZero;
    logic cntLast;
  } scanStat_t;

endpackage

// File: rtl/tmo_sweep_ctrl.sv
module tmo_sweep_ctrl
  import tmo_sweep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  scanStat_t stat,
  output scanCmd_t  cmd,
  output logic      busy,
  output logic      done
);

  scanState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.load  = 1'b1;
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        cmd.rdReq = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: begin
        cmd.capture = 1'b1;
        nextState   = stat.rdZero ? ST_ADVANCE : ST_WRITE;
      end
      ST_WRITE: begin
        cmd.wrReq = 1'b1;
        if (stat.incZero) begin
          cmd.endExpired = 1'b1;
          nextState      = ST_DONE;
        end else begin
          nextState = ST_ADVANCE;
        end
      end
      ST_ADVANCE: begin
        cmd.advance = 1'b1;
        if (stat.cntLast) begin
          cmd.endFinished = 1'b1;
          nextState       = ST_DONE;
        end else begin
          nextState = ST_READ;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R10: the end pulse lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: busy covers the done cycle
  assert_busy_through_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R9: no reload while a walk is running
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !$past(cmd.load));

endmodule

// File: rtl/tmo_sweep_dp.sv
module tmo_sweep_dp
  import tmo_sweep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int STRIDE = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scanCmd_t          cmd,
  input  logic [WORD_W-1:0] startPtr,
  input  logic [WORD_W-1:0] startCnt,
  input  logic [WORD_W-1:0] memRdata,
  output scanStat_t         stat,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] ptrOut,
  output logic [WORD_W-1:0] cntOut,
  output logic              skipOut
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(STRIDE);
  localparam logic [WORD_W-1:0] ONE  = WORD_W'(1);

  logic [WORD_W-1:0] ptrQ, cntQ, incQ;
  logic              skipQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ  <= '0;
      cntQ  <= '0;
      incQ  <= '0;
      skipQ <= 1'b0;
    end else begin
      if (cmd.load) begin
        ptrQ <= startPtr;
        cntQ <= startCnt;
      end
      if (cmd.capture)     incQ  <= memRdata + ONE;
      if (cmd.advance) begin
        ptrQ <= ptrQ + STEP;
        cntQ <= cntQ - ONE;
      end
      if (cmd.endExpired)  skipQ <= 1'b0;
      if (cmd.endFinished) skipQ <= 1'b1;
    end
  end

  always_comb begin
    memEn    = cmd.rdReq | cmd.wrReq;
    memWe    = cmd.wrReq;
    memAddr  = ptrQ;
    memWdata = incQ;
    stat.rdZero  = (memRdata == '0);
    stat.incZero = (incQ == '0);
    stat.cntLast = (cntQ == ONE);
  end

  assign ptrOut  = ptrQ;
  assign cntOut  = cntQ;
  assign skipOut = skipQ;

  // R3: an idle word (incremented to one) is never written
  assert_idle_not_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (memWdata != ONE));

  // R4: a write goes to the address read two cycles earlier
  assert_write_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> ($past(memEn, 2) && !$past(memWe, 2) && $past(memAddr, 2) == memAddr));

  // R6: advance moves the pointer by the stride and the count by one
  assert_advance_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.advance |=> (ptrQ == $past(ptrQ) + STEP) && (cntQ == $past(cntQ) - ONE));

endmodule

// File: rtl/tmo_sweep.sv
module tmo_sweep
  import tmo_sweep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int STRIDE = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] startPtr,
  input  logic [WORD_W-1:0] startCnt,
  output logic              busy,
  output logic              done,
  output logic              resultSkip,
  output logic [WORD_W-1:0] ptrOut,
  output logic [WORD_W-1:0] cntOut,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);

  scanCmd_t  cmd;
  scanStat_t stat;

  tmo_sweep_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stat  (stat),
    .cmd   (cmd),
    .busy  (busy),
    .done  (done)
  );

  tmo_sweep_dp #(.WORD_W(WORD_W), .STRIDE(STRIDE)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .startPtr (startPtr),
    .startCnt (startCnt),
    .memRdata (memRdata),
    .stat     (stat),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .ptrOut   (ptrOut),
    .cntOut   (cntOut),
    .skipOut  (resultSkip)
  );

  // R5 and R7: the end code agrees with how the walk ended
  assert_end_code_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (resultSkip ? (cntOut == '0)
                         : ($past(memWe) && ($past(memWdata) == '0))));

endmodule

// File: tb/tmo_sweep_test.sv
module tmo_sweep_test;
  localparam int MEMD = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] startPtr, startCnt;
  logic        busy, done, resultSkip;
  logic [15:0] ptrOut, cntOut;
  logic        memEn, memWe;
  logic [15:0] memAddr, memWdata, memRdata;

  always #10 clk = ~clk;  // 50 MHz

  tmo_sweep uut (
    .clk(clk), .rst_n(rst_n), .start(start), .startPtr(startPtr), .startCnt(startCnt),
    .busy(busy), .done(done), .resultSkip(resultSkip), .ptrOut(ptrOut), .cntOut(cntOut),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // memory model: addresses alias modulo MEMD, which keeps mod-2^16 wrap consistent
  logic [15:0] mem    [MEMD];
  logic [15:0] shadow [MEMD];

  always @(posedge clk) begin
    if (memEn && memWe)  mem[memAddr[11:0]] <= memWdata;
    if (memEn && !memWe) memRdata <= mem[memAddr[11:0]];
  end

  typedef struct {
    logic [15:0] ptr;
    logic [15:0] cnt;
    logic        skip;
    int          writes;
    string       tag;
  } expect_t;

  expect_t sbq[$];
  int checks = 0, errors = 0, writeCnt = 0, doneCnt = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setWord(input logic [15:0] a, input logic [15:0] v);
    mem[a[11:0]]    = v;
    shadow[a[11:0]] = v;
  endtask

  // reference model built from the requirements, working on the shadow image
  task automatic model(input logic [15:0] p, input logic [15:0] c, input string tag);
    expect_t e;
    logic [15:0] a, b, v;
    bit stop;
    a = p; b = c; stop = 0;
    e.writes = 0;
    e.skip = 1'b1;
    do begin
      v = shadow[a[11:0]] + 16'd1;
      if (v != 16'd1) begin
        shadow[a[11:0]] = v;
        e.writes++;
        if (v == 16'd0) begin
          e.skip = 1'b0;
          stop = 1;
        end
      end
      if (!stop) begin
        a = a + 16'd15;
        b = b - 16'd1;
      end
    end while (!stop && b != 16'd0);
    e.ptr = a; e.cnt = b; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: pops the scoreboard on every done
  always @(negedge clk) begin
    if (rst_n && memEn && memWe) writeCnt++;
    if (rst_n && done) begin
      doneCnt++;
      if (sbq.size() == 0) begin
        chk("R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        expect_t e;
        int mism;
        e = sbq.pop_front();
        chk(e.tag, "ptrOut", {16'd0, ptrOut}, {16'd0, e.ptr});
        chk(e.tag, "cntOut", {16'd0, cntOut}, {16'd0, e.cnt});
        chk(e.tag, "resultSkip", {31'd0, resultSkip}, {31'd0, e.skip});
        chk("R3", "write count", writeCnt, e.writes);
        mism = 0;
        for (int i = 0; i < MEMD; i++) if (mem[i] !== shadow[i]) mism++;
        chk("R4", "memory image mismatches", mism, 0);
      end
    end
  end

  // driver: model the walk, start it, optionally inject a start mid-walk
  task automatic runScan(input logic [15:0] p, input logic [15:0] c, input string tag, input int injectAt);
    int d0, cyc;
    logic [15:0] endPtr;
    d0 = doneCnt;
    model(p, c, tag);
    @(negedge clk);
    start = 1'b1; startPtr = p; startCnt = c; writeCnt = 0;
    @(negedge clk);
    start = 1'b0; startPtr = 16'hBEEF; startCnt = 16'h0003;
    chk("R1", "busy after start", {31'd0, busy}, 32'd1);
    cyc = 0;
    while (sbq.size() != 0) begin
      cyc++;
      if (injectAt != 0 && cyc == injectAt) begin
        start = 1'b1; startPtr = 16'h0123; startCnt = 16'h0002;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    endPtr = ptrOut;
    repeat (5) @(negedge clk);
    chk("R10", "single done per walk", doneCnt - d0, 1);
    chk("R10", "ptrOut holds after done", {16'd0, ptrOut}, {16'd0, endPtr});
    chk("R1", "busy low after walk", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    start = 1'b0; startPtr = '0; startCnt = '0; rst_n = 1'b0;
    for (int i = 0; i < MEMD; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", {31'd0, busy}, 32'd0);
    chk("R10", "reset done", {31'd0, done}, 32'd0);
    chk("R2", "reset memEn", {31'd0, memEn}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R7: all idle, no writes, full advance
    runScan(16'd100, 16'd4, "R3", 0);
    // R2 R4 R6: running counters that do not roll over
    setWord(16'd200, 16'd5); setWord(16'd215, 16'hFFF0);
    setWord(16'd245, 16'h7FFF);
    runScan(16'd200, 16'd4, "R6", 0);
    // R5: expire at third entry, count kept
    setWord(16'd400, 16'hFFFE); setWord(16'd430, 16'hFFFF);
    runScan(16'd400, 16'd5, "R5", 0);
    // R5: expire at first entry with count one
    setWord(16'd500, 16'hFFFF);
    runScan(16'd500, 16'd1, "R5", 0);
    // R7: single entry, not expiring
    setWord(16'd520, 16'd9);
    runScan(16'd520, 16'd1, "R7", 0);
    // R8: count zero visits first entry, wraps, stops at second
    setWord(16'd600, 16'd7); setWord(16'd615, 16'hFFFF);
    runScan(16'd600, 16'd0, "R8", 0);
    // R6: pointer wraps past the top of the address space
    setWord(16'hFFF0, 16'd1); setWord(16'hFFFF, 16'd2); setWord(16'h000E, 16'd3);
    runScan(16'hFFF0, 16'd3, "R6", 0);
    // R9: start in mid-walk is ignored
    setWord(16'd800, 16'd11); setWord(16'd815, 16'hFFFF);
    setWord(16'h0123, 16'hFFFF);
    runScan(16'd800, 16'd4, "R9", 4);
    chk("R9", "injected target untouched", {16'd0, mem[12'h123]}, 32'h0000FFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule